// File: doc/BRIEF.md
# Coin Accumulating Vend Controller

This block is the control state machine of a fixed-price dispenser. A coin sensor delivers one-cycle strobes, one for the small coin worth 5 units and one for the large coin worth 10 units. The block keeps the credit deposited so far and raises a single-cycle release signal once the credit reaches the price of 15 units. Overpayment is absorbed: the machine gives no change.

The credit is stored as a count of small-coin steps. With the default parameters it is a 2-bit code: 00 means 0 units, 01 means 5, 10 means 10 and 11 means 15. The release output is decoded from the credit register alone (Moore style), so it changes only on a clock edge. After one cycle in the full state the machine clears itself and is ready for the next purchase.

Parameters set the step value of each coin and the price, all counted in small-coin steps. The default values give the 5/10/15 machine described above.

Top module: `vend_ctrl`

## Requirements
- R1: Reset is synchronous and active high. A clock edge with `rst` high clears the credit to 0, and `open_o` is low in the cycle that follows.
- R2: A clock edge with only `nickel_i` high adds 5 units (one step) to the credit.
- R3: A clock edge with only `dime_i` high adds 10 units (two steps) to the credit.
- R4: A coin that would bring the credit to more than 15 units leaves it at the 15-unit full state, and the excess is lost.
- R5: `open_o` is high exactly while the credit is full. It rises in the cycle after the edge that sampled the coin completing the price.
- R6: `open_o` stays high for exactly one cycle. The next clock edge returns the credit to 0.
- R7: Coin strobes sampled at an edge where `open_o` is high are ignored. The credit after that edge is 0.
- R8: An edge with neither strobe high leaves the credit unchanged.
- R9: An edge with both strobes high leaves the credit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to zero credit |
| nickel_i | input | 1 | One-cycle strobe: small coin (5 units) detected |
| dime_i | input | 1 | One-cycle strobe: large coin (10 units) detected |
| open_o | output | 1 | Release signal, high for one cycle when the price is reached |

## Verification
The bench builds the block with its default parameters: coin steps of 1 and 2 and a price of 3 steps, which gives four credit states. With this configuration every ordering of four coin-strobe codes (none, small, large, both) can be swept from reset, 256 sequences in all. That sweep reaches each credit state, the overpayment from 10 to 20 units, coins arriving during the release cycle, and back-to-back purchases. A long pseudo-random run with occasional resets follows. A running-sum model that clears after each release supplies the expected value of `open_o` on every cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Coin strobe code: bit 0 small coin, bit 1 large coin
    typedef enum logic [1:0] {
        COIN_NONE  = 2'b00,
        COIN_LOW   = 2'b01,
        COIN_HIGH  = 2'b10,
        COIN_CLASH = 2'b11
    } coin_e;

    // Add a number of steps to the credit, clamped at the price
    function automatic int unsigned credit_after(input int unsigned cur,
                                                 input int unsigned add,
                                                 input int unsigned cap);
        int unsigned sum;
        sum = cur + add;
        return (sum >= cap) ? cap : sum;
    endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic  low_i,
    input  logic  high_i,
    output coin_e coin_o
);
    always_comb begin
        unique case ({high_i, low_i})
            2'b01:   coin_o = COIN_LOW;
            2'b10:   coin_o = COIN_HIGH;
            2'b11:   coin_o = COIN_CLASH;
            default: coin_o = COIN_NONE;
        endcase
    end
endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg
    import vend_pkg::*;
#(
    parameter int LOW_STEPS   = 1,
    parameter int HIGH_STEPS  = 2,
    parameter int PRICE_STEPS = 3,
    parameter int CW          = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  coin_e         coin_i,
    output logic [CW-1:0] credit_o
);
    localparam logic [CW-1:0] FULL = CW'(PRICE_STEPS);

    logic [CW-1:0] credit_q;
    logic [CW-1:0] credit_d;
    logic [31:0]   cur_wide;

    assign cur_wide = {{(32-CW){1'b0}}, credit_q};

    always_comb begin
        credit_d = credit_q;
        if (credit_q == FULL) begin
            // one release cycle, then start over; strobes here are dropped
            credit_d = '0;
        end else begin
            unique case (coin_i)
                COIN_LOW:  credit_d = CW'(credit_after(cur_wide, LOW_STEPS, PRICE_STEPS));
                COIN_HIGH: credit_d = CW'(credit_after(cur_wide, HIGH_STEPS, PRICE_STEPS));
                default:   credit_d = credit_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) credit_q <= '0;
        else     credit_q <= credit_d;
    end

    assign credit_o = credit_q;
endmodule

// File: rtl/vend_open_decode.sv
module vend_open_decode #(
    parameter int PRICE_STEPS = 3,
    parameter int CW          = 2
) (
    input  logic [CW-1:0] credit_i,
    output logic          open_o
);
    localparam logic [CW-1:0] FULL = CW'(PRICE_STEPS);

    assign open_o = (credit_i == FULL);
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int LOW_STEPS   = 1,
    parameter int HIGH_STEPS  = 2,
    parameter int PRICE_STEPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic open_o
);
    localparam int CW = $clog2(PRICE_STEPS + 1);

    coin_e         coin;
    logic [CW-1:0] credit_q;

    vend_coin_decode u_decode (
        .low_i  (nickel_i),
        .high_i (dime_i),
        .coin_o (coin)
    );

    vend_credit_reg #(
        .LOW_STEPS   (LOW_STEPS),
        .HIGH_STEPS  (HIGH_STEPS),
        .PRICE_STEPS (PRICE_STEPS),
        .CW          (CW)
    ) u_credit (
        .clk      (clk),
        .rst      (rst),
        .coin_i   (coin),
        .credit_o (credit_q)
    );

    vend_open_decode #(
        .PRICE_STEPS (PRICE_STEPS),
        .CW          (CW)
    ) u_open (
        .credit_i (credit_q),
        .open_o   (open_o)
    );
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
    parameter int PRICE_STEPS = 3,
    parameter int CW          = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          nickel_i,
    input logic          dime_i,
    input logic          open_o,
    input logic [CW-1:0] credit
);
    localparam logic [CW-1:0] FULL = CW'(PRICE_STEPS);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (credit == '0 && !open_o)); // R1

    AST_LOW_GROWS: assert property (@(posedge clk) disable iff (rst)
        (!open_o && nickel_i && !dime_i) |=> (credit > $past(credit) || credit == FULL)); // R2

    AST_HIGH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (!open_o && dime_i && !nickel_i) |=> (credit > $past(credit) || credit == FULL)); // R3

    AST_OPEN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        open_o |=> !open_o); // R6

    AST_VEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
        open_o |=> (credit == '0)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!open_o && !nickel_i && !dime_i) |=> $stable(credit)); // R8

    AST_CLASH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!open_o && nickel_i && dime_i) |=> $stable(credit)); // R9
endmodule

bind vend_ctrl vend_ctrl_chk #(
    .PRICE_STEPS (PRICE_STEPS),
    .CW          (CW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .open_o   (open_o),
    .credit   (credit_q)
);

// File: tb/test_vend_ctrl.sv
`timescale 1ns/1ps
module test_vend_ctrl;
    localparam int PRICE = 15;
    localparam int SMALL = 5;
    localparam int LARGE = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic open_o;

    int total = 0;
    int fails = 0;
    int sum = 0;
    logic prev_open = 1'b0;

    always #4 clk = ~clk;

    vend_ctrl i_vend_ctrl (
        .clk      (clk),
        .rst      (rst),
        .nickel_i (nickel),
        .dime_i   (dime),
        .open_o   (open_o)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: open_o=%0b expected %0b (credit model %0d)", tag, act, exp, sum);
        end
    endtask

    task automatic do_reset();
        nickel = 1'b0;
        dime   = 1'b0;
        rst    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(open_o, 1'b0, "R1 reset");
        rst       = 1'b0;
        sum       = 0;
        prev_open = 1'b0;
    endtask

    // drive one strobe code for one edge, then compare against the model
    task automatic step(input logic n, input logic d);
        string tag;
        logic  exp;
        int    add;
        nickel = n;
        dime   = d;
        @(posedge clk);
        @(negedge clk);
        if (prev_open) begin
            sum = 0;
            tag = (n || d) ? "R7 coin during release" : "R6 release ends";
        end else if (n && d) begin
            tag = "R9 both strobes";
        end else if (!n && !d) begin
            tag = "R8 idle";
        end else begin
            add = n ? SMALL : LARGE;
            tag = n ? "R2 small coin" : "R3 large coin";
            if (sum + add > PRICE) tag = {tag, " R4 overpay"};
            sum = (sum + add >= PRICE) ? PRICE : sum + add;
        end
        exp = (sum == PRICE);
        if (exp) tag = {tag, " R5 open"};
        check(open_o, exp, tag);
        prev_open = exp;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        do_reset();

        // directed: three small coins, release, then clear (R2 R5 R6)
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        // reset in the middle of a purchase (R1): credit 10 then cleared
        step(1'b0, 1'b1);
        do_reset();
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);

        // exhaustive sweep of four-strobe sequences from reset
        for (int s = 0; s < 256; s++) begin
            do_reset();
            for (int k = 0; k < 4; k++) begin
                logic [1:0] code;
                code = 2'((s >> (2 * k)) & 3);
                step(code[0], code[1]);
            end
        end

        // long pseudo-random run with sparse resets
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] code;
            if (($urandom % 53) == 0) begin
                do_reset();
            end else begin
                code = 2'($urandom % 4);
                step(code[0], code[1]);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end
endmodule